// File: doc/BRIEF.md
# Thermal Alert Decision Logic with Fault Queue

This block owns the alert output of a digital temperature sensor. Every time the converter finishes a measurement it pulses `conv_done` with the new 12-bit two's-complement reading. The block compares that reading with a high limit and a low limit. It counts consecutive results that meet the condition currently armed, and changes the alert only once the programmed number of back-to-back results has been seen. A short run of noisy readings therefore cannot toggle the pin.

Two behaviours are selectable. In comparator mode the alert acts like a thermostat with hysteresis: it turns on at or above the high limit and turns off below the low limit. In interrupt mode the alert is latched. Software acknowledges it by reading any register, by winning an alert-response query, or by putting the sensor into shutdown. The trigger condition then alternates between crossing the high limit and falling below the low limit. The surrounding bus interface uses `ara_respond` and `ara_byte` to answer an alert-response query (the interface matches the query address 0001100 with the read bit). That byte carries the device address and a bit giving the cause of the alert. The interface also reports whether this device won address arbitration on that query.

Top module: `therm_alert`

## Requirements
- R1: `fq_sel` sets the number of consecutive qualifying conversions needed to change the alert: 00 needs 1, 01 needs 2, 10 needs 4, 11 needs 6.
- R2: In comparator mode (`irq_mode`=0) an inactive alert becomes active once the required number of consecutive conversions have temperature greater than or equal to `hi_lim`.
- R3: In comparator mode an active alert becomes inactive only after the required number of consecutive conversions with temperature strictly less than `lo_lim`. A register read, alert-response outcome or shutdown has no effect on it.
- R4: A conversion that does not meet the currently armed condition restarts the consecutive count from zero.
- R5: In interrupt mode (`irq_mode`=1) the alert asserts after the required run at or above `hi_lim`. It then stays active through further conversions until a `reg_read` pulse, an `ara_done` pulse with `ara_won`=1, or a rising edge of `shutdown`.
- R6: After an interrupt-mode clear, the next assertion needs the required run below `lo_lim`. Once that alert is cleared, the following assertion again needs the run at or above `hi_lim`.
- R7: An `ara_done` pulse with `ara_won`=0 leaves an active interrupt-mode alert active.
- R8: With `pol_high`=0 the `alert_pin` is low when the alert is active. With `pol_high`=1 it is high when active.
- R9: `ara_respond` equals the internal alert state. `ara_byte` is {`dev_addr`[6:0], cause}. The cause bit is 1 when the alert was raised by the high limit and 0 when it was raised by the low limit.
- R10: A `gc_reset` pulse returns the block to its power-up state: alert inactive, count zero, interrupt arming on the high limit.
- R11: Comparisons are signed over all 12 bits, so negative readings and negative limits order correctly.
- R12: The alert state changes only in the clock cycle after a `conv_done` pulse or a clearing event. Temperature and limits are ignored while `conv_done` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_done | input | 1 | One-cycle pulse: a new reading is on `temp_in` |
| temp_in | input | 12 | Latest reading, two's complement |
| hi_lim | input | 12 | High limit, two's complement |
| lo_lim | input | 12 | Low limit, two's complement |
| irq_mode | input | 1 | 0 comparator behaviour, 1 latched interrupt behaviour |
| pol_high | input | 1 | 1 makes `alert_pin` active high |
| fq_sel | input | 2 | Consecutive-fault count select |
| reg_read | input | 1 | Pulse: any register was read |
| shutdown | input | 1 | Shutdown setting; its rising edge clears an interrupt alert |
| ara_done | input | 1 | Pulse: an alert-response query this block answered has finished |
| ara_won | input | 1 | Qualifies `ara_done`: this device won arbitration |
| gc_reset | input | 1 | Pulse: general-call reset |
| dev_addr | input | 7 | This device's bus address |
| alert_pin | output | 1 | Alert output after polarity |
| alert_active | output | 1 | Alert state before polarity |
| ara_respond | output | 1 | Block should answer an alert-response query |
| ara_byte | output | 8 | Address byte to return, cause in bit 0 |

## Verification
A corrupted consecutive count shows up as an alert that changes one or more conversions too early or too late. The bench probes every queue depth at exactly n-1 and n results, so an off-by-one shows at the first boundary conversion. A wrong interrupt arming bit shows as an alert that fails to appear, or appears on the wrong limit, at the first conversion after a clear. The cause bit in `ara_byte` exposes the same fault in that same cycle. Lost clears, or clears taken in comparator mode, appear on `alert_pin` in the cycle after the clearing pulse.

// File: rtl/therm_alert_pkg.sv
package therm_alert_pkg;

    localparam int TEMP_W = 12;
    localparam int ADDR_W = 7;
    localparam int QCNT_W = 3;

    // alert-response query address, matched by the bus interface
    localparam logic [ADDR_W-1:0] ARA_QUERY_ADDR = 7'b0001100;

    typedef enum logic [1:0] {
        FQ_DEPTH1 = 2'b00,
        FQ_DEPTH2 = 2'b01,
        FQ_DEPTH4 = 2'b10,
        FQ_DEPTH6 = 2'b11
    } fq_sel_e;

    typedef struct packed {
        logic active;    // alert asserted (before polarity)
        logic armed_hi;  // interrupt mode: next trigger is the high limit
        logic cause;     // 1 = raised by high limit, 0 = by low limit
    } alert_st_t;

    localparam alert_st_t ALERT_RESET = '{active: 1'b0, armed_hi: 1'b1, cause: 1'b1};

    function automatic logic [QCNT_W-1:0] fq_depth(input fq_sel_e sel);
        case (sel)
            FQ_DEPTH1: fq_depth = 3'd1;
            FQ_DEPTH2: fq_depth = 3'd2;
            FQ_DEPTH4: fq_depth = 3'd4;
            default:   fq_depth = 3'd6;
        endcase
    endfunction

endpackage

// File: rtl/therm_limit_cmp.sv
module therm_limit_cmp #(
    parameter int W = therm_alert_pkg::TEMP_W
) (
    input  logic [W-1:0] temp,
    input  logic [W-1:0] hi_lim,
    input  logic [W-1:0] lo_lim,
    output logic         ge_hi,
    output logic         lt_lo
);
    // full-width signed compares, independent of converter resolution
    assign ge_hi = $signed(temp) >= $signed(hi_lim);
    assign lt_lo = $signed(temp) <  $signed(lo_lim);
endmodule

// File: rtl/therm_fault_queue.sv
module therm_fault_queue
    import therm_alert_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic       sample,
    input  logic       cond,
    input  logic [1:0] sel,
    output logic       hit
);
    logic [QCNT_W-1:0] cnt;
    logic [QCNT_W-1:0] depth;
    logic [QCNT_W:0]   cnt_inc;

    assign depth   = fq_depth(fq_sel_e'(sel));
    assign cnt_inc = {1'b0, cnt} + 1'b1;
    assign hit     = sample && cond && (cnt_inc >= {1'b0, depth});

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (sample) begin
            if (!cond || hit) cnt <= '0;
            else              cnt <= cnt_inc[QCNT_W-1:0];
        end
    end

    p_cnt_bound_r1: assert property (@(posedge clk) disable iff (rst)
        cnt < 3'd6);

    p_miss_restarts_r4: assert property (@(posedge clk) disable iff (rst)
        (sample && !cond) |=> (cnt == '0));

    p_hold_without_sample_r12: assert property (@(posedge clk) disable iff (rst)
        (!sample && !clr) |=> $stable(cnt));
endmodule

// File: rtl/therm_alert.sv
module therm_alert
    import therm_alert_pkg::*;
#(
    parameter int TW = TEMP_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          conv_done,
    input  logic [TW-1:0] temp_in,
    input  logic [TW-1:0] hi_lim,
    input  logic [TW-1:0] lo_lim,
    input  logic          irq_mode,
    input  logic          pol_high,
    input  logic [1:0]    fq_sel,
    input  logic          reg_read,
    input  logic          shutdown,
    input  logic          ara_done,
    input  logic          ara_won,
    input  logic          gc_reset,
    input  logic [AW-1:0] dev_addr,
    output logic          alert_pin,
    output logic          alert_active,
    output logic          ara_respond,
    output logic [AW:0]   ara_byte
);
    alert_st_t st, st_nxt;
    logic      sd_q;
    logic      ge_hi, lt_lo;
    logic      cond, hit, clr_evt;

    therm_limit_cmp #(.W(TW)) u_cmp (
        .temp   (temp_in),
        .hi_lim (hi_lim),
        .lo_lim (lo_lim),
        .ge_hi  (ge_hi),
        .lt_lo  (lt_lo)
    );

    // condition that advances the queue in the current state
    always_comb begin
        if (irq_mode) cond = !st.active && (st.armed_hi ? ge_hi : lt_lo);
        else          cond = st.active ? lt_lo : ge_hi;
    end

    therm_fault_queue u_fq (
        .clk    (clk),
        .rst    (rst),
        .clr    (gc_reset),
        .sample (conv_done),
        .cond   (cond),
        .sel    (fq_sel),
        .hit    (hit)
    );

    assign clr_evt = irq_mode && (reg_read || (ara_done && ara_won) || (shutdown && !sd_q));

    always_comb begin
        st_nxt = st;
        if (hit) begin
            if (irq_mode) begin
                st_nxt.active   = 1'b1;
                st_nxt.cause    = st.armed_hi;
                st_nxt.armed_hi = !st.armed_hi;
            end else begin
                st_nxt.active = !st.active;
                if (!st.active) st_nxt.cause = 1'b1;
            end
        end else if (clr_evt) begin
            st_nxt.active = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || gc_reset) st <= ALERT_RESET;
        else                 st <= st_nxt;
        if (rst) sd_q <= 1'b0;
        else     sd_q <= shutdown;
    end

    assign alert_active = st.active;
    assign alert_pin    = pol_high ? st.active : !st.active;
    assign ara_respond  = st.active;
    assign ara_byte     = {dev_addr, st.cause};

    p_gc_clears_r10: assert property (@(posedge clk) disable iff (rst)
        gc_reset |=> !alert_active);

    p_cmp_stable_r3: assert property (@(posedge clk) disable iff (rst)
        (!irq_mode && !conv_done && !gc_reset) |=> $stable(st.active));

    p_rise_needs_conv_r12: assert property (@(posedge clk) disable iff (rst)
        $rose(st.active) |-> $past(conv_done));

    p_read_clears_r5: assert property (@(posedge clk) disable iff (rst)
        (irq_mode && reg_read && !conv_done) |=> !st.active);

    p_lost_keeps_r7: assert property (@(posedge clk) disable iff (rst)
        (irq_mode && st.active && ara_done && !ara_won && !reg_read &&
         !(shutdown && !sd_q) && !gc_reset) |=> st.active);

    p_irq_cause_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (irq_mode && st.active && !gc_reset) |=> $stable(st.cause));
endmodule

// File: tb/therm_alert_test.sv
module therm_alert_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        conv_done = 1'b0;
    logic [11:0] temp_in = '0;
    logic [11:0] hi_lim = 12'h500;
    logic [11:0] lo_lim = 12'h4B0;
    logic        irq_mode = 1'b0;
    logic        pol_high = 1'b0;
    logic [1:0]  fq_sel = 2'b00;
    logic        reg_read = 1'b0;
    logic        shutdown = 1'b0;
    logic        ara_done = 1'b0;
    logic        ara_won = 1'b0;
    logic        gc_reset = 1'b0;
    logic [6:0]  dev_addr = 7'b1001000;
    logic        alert_pin, alert_active, ara_respond;
    logic [7:0]  ara_byte;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    localparam logic [11:0] HOT  = 12'h500; // equals high limit
    localparam logic [11:0] MID  = 12'h4B0; // equals low limit, not below
    localparam logic [11:0] COLD = 12'h4AF; // just below low limit

    always #2 clk = ~clk;

    therm_alert uut (
        .clk(clk), .rst(rst), .conv_done(conv_done), .temp_in(temp_in),
        .hi_lim(hi_lim), .lo_lim(lo_lim), .irq_mode(irq_mode), .pol_high(pol_high),
        .fq_sel(fq_sel), .reg_read(reg_read), .shutdown(shutdown),
        .ara_done(ara_done), .ara_won(ara_won), .gc_reset(gc_reset),
        .dev_addr(dev_addr), .alert_pin(alert_pin), .alert_active(alert_active),
        .ara_respond(ara_respond), .ara_byte(ara_byte)
    );

    task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // checks the alert through the pin, using the current polarity
    task automatic chk_alert(input string req, input logic exp_active);
        chk(req, "alert_pin", {7'b0, alert_pin}, {7'b0, pol_high ? exp_active : !exp_active});
        chk(req, "ara_respond", {7'b0, ara_respond}, {7'b0, exp_active});
    endtask

    task automatic conv(input logic [11:0] t);
        @(negedge clk); temp_in = t; conv_done = 1'b1;
        @(negedge clk); conv_done = 1'b0; temp_in = 12'h000;
    endtask

    task automatic pulse_gc();
        @(negedge clk); gc_reset = 1'b1;
        @(negedge clk); gc_reset = 1'b0;
    endtask

    task automatic pulse_read();
        @(negedge clk); reg_read = 1'b1;
        @(negedge clk); reg_read = 1'b0;
    endtask

    task automatic pulse_ara(input logic won);
        @(negedge clk); ara_done = 1'b1; ara_won = won;
        @(negedge clk); ara_done = 1'b0; ara_won = 1'b0;
    endtask

    task automatic t_reset();
        chk("R10", "reset pin", {7'b0, alert_pin}, 8'h01);
        chk("R10", "reset respond", {7'b0, ara_respond}, 8'h00);
    endtask

    task automatic t_cmp_depths();
        for (int s = 0; s < 4; s++) begin
            int n;
            n = (s == 0) ? 1 : (s == 1) ? 2 : (s == 2) ? 4 : 6;
            pulse_gc();
            irq_mode = 1'b0; fq_sel = s[1:0];
            for (int k = 0; k < n - 1; k++) conv(HOT);
            chk_alert("R1", 1'b0);
            conv(HOT);
            chk_alert("R2", 1'b1);
            for (int k = 0; k < n - 1; k++) conv(COLD);
            chk_alert("R3", 1'b1);
            conv(COLD);
            chk_alert("R3", 1'b0);
        end
    endtask

    task automatic t_cmp_break();
        pulse_gc();
        irq_mode = 1'b0; fq_sel = 2'b10;
        repeat (3) conv(HOT);
        conv(12'h4FF);
        repeat (3) conv(HOT);
        chk_alert("R4", 1'b0);
        conv(HOT);
        chk_alert("R4", 1'b1);
        pulse_read();
        pulse_ara(1'b1);
        @(negedge clk); shutdown = 1'b1;
        @(negedge clk); shutdown = 1'b0;
        chk_alert("R3", 1'b1);
        repeat (3) conv(COLD);
        conv(MID);
        repeat (3) conv(COLD);
        chk_alert("R4", 1'b1);
        conv(COLD);
        chk_alert("R4", 1'b0);
    endtask

    task automatic t_idle();
        pulse_gc();
        irq_mode = 1'b0; fq_sel = 2'b00;
        @(negedge clk); temp_in = 12'h7FF;
        repeat (20) @(negedge clk);
        chk_alert("R12", 1'b0);
        temp_in = 12'h000;
    endtask

    task automatic t_irq();
        pulse_gc();
        irq_mode = 1'b1; fq_sel = 2'b01;
        conv(HOT);
        chk_alert("R5", 1'b0);
        conv(HOT);
        chk_alert("R5", 1'b1);
        chk("R9", "ara_byte high", ara_byte, {dev_addr, 1'b1});
        conv(COLD); conv(COLD); conv(HOT);
        chk_alert("R5", 1'b1);
        pulse_read();
        chk_alert("R5", 1'b0);
        conv(HOT); conv(HOT); conv(HOT);
        chk_alert("R6", 1'b0);
        conv(COLD);
        chk_alert("R6", 1'b0);
        conv(COLD);
        chk_alert("R6", 1'b1);
        chk("R9", "ara_byte low", ara_byte, {dev_addr, 1'b0});
        pulse_ara(1'b0);
        chk_alert("R7", 1'b1);
        pulse_ara(1'b1);
        chk_alert("R5", 1'b0);
        conv(COLD); conv(COLD);
        chk_alert("R6", 1'b0);
        conv(HOT); conv(HOT);
        chk_alert("R6", 1'b1);
        chk("R9", "ara_byte rearm", ara_byte, {dev_addr, 1'b1});
        @(negedge clk); shutdown = 1'b1;
        @(negedge clk);
        chk_alert("R5", 1'b0);
        @(negedge clk); shutdown = 1'b0;
    endtask

    task automatic t_pol();
        pulse_gc();
        irq_mode = 1'b0; fq_sel = 2'b00; pol_high = 1'b1;
        @(negedge clk);
        chk("R8", "pin inactive high-pol", {7'b0, alert_pin}, 8'h00);
        conv(HOT);
        chk("R8", "pin active high-pol", {7'b0, alert_pin}, 8'h01);
        pol_high = 1'b0;
        @(negedge clk);
        chk("R8", "pin active low-pol", {7'b0, alert_pin}, 8'h00);
    endtask

    task automatic t_signed();
        pulse_gc();
        irq_mode = 1'b0; fq_sel = 2'b00;
        hi_lim = 12'h000; lo_lim = 12'hE70;
        conv(12'hFFC);
        chk_alert("R11", 1'b0);
        conv(12'h004);
        chk_alert("R11", 1'b1);
        conv(12'hE80);
        chk_alert("R11", 1'b1);
        conv(12'hC90);
        chk_alert("R11", 1'b0);
        hi_lim = 12'h500; lo_lim = 12'h4B0;
    endtask

    task automatic t_gc();
        pulse_gc();
        irq_mode = 1'b1; fq_sel = 2'b00;
        conv(HOT);
        chk_alert("R10", 1'b1);
        pulse_gc();
        chk_alert("R10", 1'b0);
        conv(COLD);
        chk_alert("R10", 1'b0);
        conv(HOT);
        chk_alert("R10", 1'b1);
        fq_sel = 2'b10;
        pulse_read();
        conv(COLD); conv(COLD); conv(COLD);
        pulse_gc();
        fq_sel = 2'b00; irq_mode = 1'b0;
        conv(HOT);
        chk_alert("R10", 1'b1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_cmp_depths();
        t_cmp_break();
        t_idle();
        t_irq();
        t_pol();
        t_signed();
        t_gc();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #400000;
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule